// File: doc/BRIEF.md
# Serial Link Response Receiver and Busy Poller

This block takes over a single-wire serial link once a command frame has gone out. It releases the data line and sends clock pulses to the slave. It searches for a start bit, then decodes the reply header, which holds a slave address and a response code. On an acknowledge it captures any read data and checks the 4-bit checksum on the reply. When the slave answers busy, the block hands the line back to the transmitter so that a poll command can be sent, and then searches for a start bit again. The number of busy answers it accepts is bounded.

Every path ends with a one-cycle completion strobe and a status code. Error paths first clock out a fixed number of drain bits, so that the slave can finish any reply still in flight. Successful paths first give the slave a fixed run of priming pulses, so that it is ready for the next command. The line is active low: a low level on the wire is a logical 1.

Top module: `link_resp_rx`

## Requirements
- R1: A `start_i` accepted while idle makes `line_clk_o` pulse from the next cycle. `line_oe_o` is 0 (line released) in every pulsing cycle and 1 while idle or waiting for a poll.
- R2: Each `line_clk_o` cycle samples one bit, whose logical value is the inverse of `line_in_i`. Bits arrive MSB first, and the start bit is a logical 1.
- R3: If no start bit appears within TMO_CLKS (1000) search pulses, the block gives 20 drain pulses and then reports status 1 (timeout). A start bit on the last permitted search pulse is still accepted.
- R4: After the start bit come 2 slave-address bits and then 2 response-code bits. The codes are 0 ACK, 1 BUSY, 2 general error, 3 slave-detected command checksum error.
- R5: Response code 2 gives 20 drain pulses and then status 3. Response code 3 gives 20 drain pulses and then status 4.
- R6: An ACK to a read is followed by 8×`nbytes_i` data bits, which land right-aligned in `rd_data_o`. An ACK to a write has no data bits, and `rd_data_o` keeps its previous value.
- R7: Four checksum bits follow the ACK header and data. The checksum starts at 0, takes in the start bit, address, code and data bits, and each step computes m = bit XOR c[3], c = (c<<1) XOR {0,m,m,m}. A match gives status 0 and a mismatch gives status 5.
- R8: After the checksum bits, 100 priming pulses are issued whether or not the checksum matched, and then done is raised.
- R9: On BUSY the block stops pulsing and raises `poll_req_o` until `poll_done_i`, then restarts the start-bit search. It grants 100 polls, and the 101st BUSY reports status 2 at once, without draining.
- R10: `done_o` lasts exactly one cycle and directly follows a pulsing cycle. `status_o` changes only together with `done_o` and is held afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin receiving a reply (taken when idle) |
| is_read_i | input | 1 | The command sent was a read |
| nbytes_i | input | 3 | Read length in bytes, 1..4 |
| line_in_i | input | 1 | Raw data line level (active low) |
| poll_done_i | input | 1 | Transmitter has finished sending the poll command |
| line_clk_o | output | 1 | One link clock pulse this cycle; the bit is sampled at its end |
| line_oe_o | output | 1 | 1 when the data line may be driven by the master side |
| poll_req_o | output | 1 | Request for a poll command, held until poll_done_i |
| done_o | output | 1 | One-cycle completion strobe |
| status_o | output | 3 | 0 ok, 1 timeout, 2 busy stuck, 3 general error, 4 command checksum error, 5 reply checksum error |
| rd_data_o | output | 32 | Captured read data, right-aligned |

## Verification
Two decisions can fall on the same cycle, and both are provoked on purpose. In the first, the start bit arrives on the very pulse where the search counter reaches its limit. A reply delayed by 999 idle bits must still be accepted, while one delayed by 1000 must produce a timeout and drain. In the second, a BUSY code arrives just as the retry count reaches its limit. A run of 101 BUSY replies must end with exactly 100 poll handshakes and a busy-stuck status, where one fewer BUSY would have started another poll. Each case is judged by the pulse count, the poll count and the status seen at the done strobe, measured against a bit-level slave model.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEARCH = 3'd1,
        ST_HDR    = 3'd2,
        ST_DATA   = 3'd3,
        ST_CRC    = 3'd4,
        ST_PRIME  = 3'd5,
        ST_DRAIN  = 3'd6,
        ST_POLL   = 3'd7
    } rx_state_e;

    typedef enum logic [2:0] {
        RS_OK         = 3'd0,
        RS_TIMEOUT    = 3'd1,
        RS_BUSY_STUCK = 3'd2,
        RS_ERR_GEN    = 3'd3,
        RS_ERR_CMD    = 3'd4,
        RS_CRC_BAD    = 3'd5
    } rx_status_e;

    // one step of the 4-bit reply checksum
    function automatic logic [3:0] crc4_next(input logic [3:0] c, input logic b);
        logic m;
        m = b ^ c[3];
        return {c[2:0], 1'b0} ^ {1'b0, m, m, m};
    endfunction

endpackage

// File: rtl/rsp_crc4.sv
module rsp_crc4 (
    input  logic [3:0] crc_i,
    input  logic       bit_i,
    output logic [3:0] crc_o
);
    always_comb crc_o = rsp_pkg::crc4_next(crc_i, bit_i);
endmodule

// File: rtl/rsp_term_sel.sv
module rsp_term_sel #(
    parameter int TMO_CLKS   = 1000,
    parameter int DRAIN_BITS = 20,
    parameter int PRIME_CLKS = 100,
    parameter int NB_W       = 3,
    parameter int CNT_W      = 10
) (
    input  rsp_pkg::rx_state_e state_i,
    input  logic [NB_W-1:0]    nbytes_i,
    output logic [CNT_W-1:0]   last_o
);
    logic [NB_W-1:0]  nb_eff;
    logic [CNT_W-1:0] data_bits;

    always_comb begin
        nb_eff    = (nbytes_i == '0) ? NB_W'(1) : nbytes_i;
        data_bits = CNT_W'({nb_eff, 3'b000});
        case (state_i)
            rsp_pkg::ST_SEARCH: last_o = CNT_W'(TMO_CLKS - 1);
            rsp_pkg::ST_HDR:    last_o = CNT_W'(3);
            rsp_pkg::ST_DATA:   last_o = data_bits - CNT_W'(1);
            rsp_pkg::ST_CRC:    last_o = CNT_W'(3);
            rsp_pkg::ST_PRIME:  last_o = CNT_W'(PRIME_CLKS - 1);
            rsp_pkg::ST_DRAIN:  last_o = CNT_W'(DRAIN_BITS - 1);
            default:            last_o = '0;
        endcase
    end
endmodule

// File: rtl/link_resp_rx.sv
module link_resp_rx #(
    parameter int TMO_CLKS   = 1000,
    parameter int MAX_BUSY   = 100,
    parameter int DRAIN_BITS = 20,
    parameter int PRIME_CLKS = 100,
    parameter int MAX_BYTES  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   is_read_i,
    input  logic [2:0]             nbytes_i,
    input  logic                   line_in_i,
    input  logic                   poll_done_i,
    output logic                   line_clk_o,
    output logic                   line_oe_o,
    output logic                   poll_req_o,
    output logic                   done_o,
    output logic [2:0]             status_o,
    output logic [8*MAX_BYTES-1:0] rd_data_o
);
    import rsp_pkg::*;

    localparam int DATA_W  = 8 * MAX_BYTES;
    localparam int NB_W    = 3;
    localparam int M1      = (TMO_CLKS > PRIME_CLKS) ? TMO_CLKS : PRIME_CLKS;
    localparam int M2      = (DRAIN_BITS > DATA_W) ? DRAIN_BITS : DATA_W;
    localparam int CNT_MAX = (M1 > M2) ? M1 : M2;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int BUSY_W  = $clog2(MAX_BUSY + 1);

    typedef struct packed {
        rx_state_e         state;
        logic [CNT_W-1:0]  cnt;
        logic [BUSY_W-1:0] busy;
        logic [3:0]        crc;
        logic [2:0]        hdr;
        logic [DATA_W-1:0] shreg;
        logic [DATA_W-1:0] rd_data;
        logic              is_rd;
        logic [NB_W-1:0]   nbytes;
        rx_status_e        code;
        rx_status_e        status;
        logic              done;
    } rx_regs_t;

    rx_regs_t q, d;

    logic             rx_bit;
    logic [3:0]       crc_in, crc_nx;
    logic [CNT_W-1:0] term;
    logic             at_term;

    assign rx_bit  = ~line_in_i;
    assign crc_in  = (q.state == ST_SEARCH) ? 4'd0 : q.crc;
    assign at_term = (q.cnt == term);

    rsp_crc4 u_crc (.crc_i(crc_in), .bit_i(rx_bit), .crc_o(crc_nx));

    rsp_term_sel #(
        .TMO_CLKS(TMO_CLKS), .DRAIN_BITS(DRAIN_BITS), .PRIME_CLKS(PRIME_CLKS),
        .NB_W(NB_W), .CNT_W(CNT_W)
    ) u_term (.state_i(q.state), .nbytes_i(q.nbytes), .last_o(term));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.state  = ST_SEARCH;
                    d.cnt    = '0;
                    d.busy   = '0;
                    d.is_rd  = is_read_i;
                    d.nbytes = nbytes_i;
                    d.shreg  = '0;
                end
            end
            ST_SEARCH: begin
                if (rx_bit) begin
                    d.state = ST_HDR;
                    d.cnt   = '0;
                    d.crc   = crc_nx;
                end else if (at_term) begin
                    d.state = ST_DRAIN;
                    d.cnt   = '0;
                    d.code  = RS_TIMEOUT;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_HDR: begin
                d.hdr = {q.hdr[1:0], rx_bit};
                d.crc = crc_nx;
                d.cnt = q.cnt + 1'b1;
                if (at_term) begin
                    d.cnt = '0;
                    case ({q.hdr[0], rx_bit})
                        2'd0: d.state = q.is_rd ? ST_DATA : ST_CRC;
                        2'd1: begin
                            if (q.busy == BUSY_W'(MAX_BUSY)) begin
                                d.state  = ST_IDLE;
                                d.done   = 1'b1;
                                d.status = RS_BUSY_STUCK;
                            end else begin
                                d.busy  = q.busy + 1'b1;
                                d.state = ST_POLL;
                            end
                        end
                        2'd2: begin
                            d.state = ST_DRAIN;
                            d.code  = RS_ERR_GEN;
                        end
                        default: begin
                            d.state = ST_DRAIN;
                            d.code  = RS_ERR_CMD;
                        end
                    endcase
                end
            end
            ST_DATA: begin
                d.shreg = {q.shreg[DATA_W-2:0], rx_bit};
                d.crc   = crc_nx;
                d.cnt   = q.cnt + 1'b1;
                if (at_term) begin
                    d.state = ST_CRC;
                    d.cnt   = '0;
                end
            end
            ST_CRC: begin
                d.hdr = {q.hdr[1:0], rx_bit};
                d.cnt = q.cnt + 1'b1;
                if (at_term) begin
                    d.state = ST_PRIME;
                    d.cnt   = '0;
                    d.code  = ({q.hdr, rx_bit} == q.crc) ? RS_OK : RS_CRC_BAD;
                    if (q.is_rd) d.rd_data = q.shreg;
                end
            end
            ST_PRIME, ST_DRAIN: begin
                d.cnt = q.cnt + 1'b1;
                if (at_term) begin
                    d.state  = ST_IDLE;
                    d.done   = 1'b1;
                    d.status = q.code;
                end
            end
            ST_POLL: begin
                if (poll_done_i) begin
                    d.state = ST_SEARCH;
                    d.cnt   = '0;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_clk_o = (q.state != ST_IDLE) && (q.state != ST_POLL);
    assign line_oe_o  = (q.state == ST_IDLE) || (q.state == ST_POLL);
    assign poll_req_o = (q.state == ST_POLL);
    assign done_o     = q.done;
    assign status_o   = q.status;
    assign rd_data_o  = q.rd_data;

endmodule

// File: rtl/link_resp_rx_chk.sv
module link_resp_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       poll_done_i,
    input logic       line_clk_o,
    input logic       line_oe_o,
    input logic       poll_req_o,
    input logic       done_o,
    input logic [2:0] status_o
);
    AST_START_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !line_clk_o && !poll_req_o) |=> line_clk_o); // R1
    AST_LINE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        line_clk_o |-> !line_oe_o); // R1
    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req_o |-> (!line_clk_o && line_oe_o)); // R9
    AST_POLL_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_req_o && poll_done_i) |=> (line_clk_o && !poll_req_o)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(line_clk_o)); // R8
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o <= 3'd5)); // R10
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(status_o)); // R10
endmodule

bind link_resp_rx link_resp_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .poll_done_i(poll_done_i),
    .line_clk_o(line_clk_o), .line_oe_o(line_oe_o), .poll_req_o(poll_req_o),
    .done_o(done_o), .status_o(status_o)
);

// File: tb/tb_link_resp_rx.sv
`timescale 1ns/1ps
module tb_link_resp_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        is_read_i = 1'b0;
    logic [2:0]  nbytes_i = 3'd1;
    logic        line_in_i = 1'b1;
    logic        poll_done_i = 1'b0;
    logic        line_clk_o, line_oe_o, poll_req_o, done_o;
    logic [2:0]  status_o;
    logic [31:0] rd_data_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] last_data = '0;

    bit          sq[$];
    logic [63:0] rq_bits[$];
    int          rq_len[$];
    int          rq_dly[$];

    always #4 clk = ~clk;

    link_resp_rx dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_read_i(is_read_i),
        .nbytes_i(nbytes_i), .line_in_i(line_in_i), .poll_done_i(poll_done_i),
        .line_clk_o(line_clk_o), .line_oe_o(line_oe_o), .poll_req_o(poll_req_o),
        .done_o(done_o), .status_o(status_o), .rd_data_o(rd_data_o)
    );

    function automatic logic [3:0] crc_step(logic [3:0] c, logic b);
        logic m;
        m = b ^ c[3];
        return {c[2:0], 1'b0} ^ {1'b0, m, m, m};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // queue one slave reply: dly idle bits, start, id, code, data, checksum
    task automatic add_resp(int dly, int id, int code, int nb, logic [31:0] data, bit bad);
        logic [63:0] v = '0;
        int          len = 0;
        logic [3:0]  c;
        c = crc_step(4'd0, 1'b1);
        v = {v[62:0], 1'b1}; len++;
        for (int i = 1; i >= 0; i--) begin v = {v[62:0], id[i]};   c = crc_step(c, id[i]);   len++; end
        for (int i = 1; i >= 0; i--) begin v = {v[62:0], code[i]}; c = crc_step(c, code[i]); len++; end
        if (code == 0) begin
            for (int i = 8*nb-1; i >= 0; i--) begin v = {v[62:0], data[i]}; c = crc_step(c, data[i]); len++; end
            if (bad) c = c ^ 4'b0101;
            for (int i = 3; i >= 0; i--) begin v = {v[62:0], c[i]}; len++; end
        end
        rq_bits.push_back(v);
        rq_len.push_back(len);
        rq_dly.push_back(dly);
    endtask

    task automatic load_next();
        if (rq_len.size() != 0) begin
            logic [63:0] v;
            int len, dly;
            v = rq_bits.pop_front();
            len = rq_len.pop_front();
            dly = rq_dly.pop_front();
            repeat (dly) sq.push_back(1'b0);
            for (int i = len-1; i >= 0; i--) sq.push_back(v[i]);
        end
    endtask

    // cycle-by-cycle slave model and monitor for one transaction
    task automatic run_txn(string req, bit rd, int nb, int exp_status,
                           int exp_pulses, int exp_polls, logic [31:0] exp_data);
        int pulses = 0, polls = 0, wcnt = 0, cyc = 0;
        bit got = 0, prev_clk = 0, oe_ok = 1;
        @(negedge clk);
        start_i = 1'b1; is_read_i = rd; nbytes_i = nb[2:0];
        load_next();
        while (!got && cyc < 6000) begin
            @(negedge clk);
            start_i = 1'b0;
            poll_done_i = 1'b0;
            cyc++;
            if (line_oe_o !== !line_clk_o) oe_ok = 0;
            if (done_o) begin
                got = 1;
                check(prev_clk, "R10", "done follows pulse", 0, 1);
                check(status_o == exp_status[2:0], req, "status", status_o, exp_status);
                check(pulses == exp_pulses, req, "pulse count", pulses, exp_pulses);
                check(polls == exp_polls, "R9", "poll count", polls, exp_polls);
                check(rd_data_o == exp_data, req, "rd_data", rd_data_o, exp_data);
            end
            prev_clk = line_clk_o;
            if (line_clk_o) begin
                pulses++;
                line_in_i = (sq.size() != 0) ? ~sq.pop_front() : 1'b1;
            end else begin
                line_in_i = 1'b1;
            end
            if (poll_req_o) begin
                wcnt++;
                if (wcnt == 3) begin
                    load_next();
                    poll_done_i = 1'b1;
                    polls++;
                    wcnt = 0;
                end
            end
        end
        check(got, req, "done seen", got, 1);
        check(oe_ok, "R1", "line released while pulsing", oe_ok, 1);
        @(negedge clk);
        check(!done_o, "R10", "done one cycle", done_o, 0);
        sq.delete(); rq_bits.delete(); rq_len.delete(); rq_dly.delete();
        last_data = exp_data;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done_o, "R10", "reset done", done_o, 0);
        check(!line_clk_o && line_oe_o, "R1", "reset idle line", line_clk_o, 0);
        check(!poll_req_o, "R9", "reset poll_req", poll_req_o, 0);
        check(status_o == 3'd0 && rd_data_o == '0, "R10", "reset status/data", status_o, 0);

        // R2: 4-byte read, inverted MSB-first data
        add_resp(3, 1, 0, 4, 32'hA5C30F81, 0);
        run_txn("R2", 1, 4, 0, 3+5+32+4+100, 0, 32'hA5C30F81);
        // R6: 1-byte read right-aligned
        add_resp(0, 2, 0, 1, 32'h5A, 0);
        run_txn("R6", 1, 1, 0, 5+8+4+100, 0, 32'h5A);
        // R7: bad checksum still primes and captures
        add_resp(2, 3, 0, 2, 32'h1234, 1);
        run_txn("R7", 1, 2, 5, 2+5+16+4+100, 0, 32'h1234);
        // R6: write ack, no data bits, rd_data kept
        add_resp(1, 0, 0, 0, 32'h0, 0);
        run_txn("R6", 0, 1, 0, 1+5+4+100, 0, last_data);
        // R5: general error drains
        add_resp(4, 1, 2, 0, 32'h0, 0);
        run_txn("R5", 0, 1, 3, 4+5+20, 0, last_data);
        // R5: command checksum error on read drains
        add_resp(0, 2, 3, 0, 32'h0, 0);
        run_txn("R5", 1, 4, 4, 5+20, 0, last_data);
        // R3: silent slave
        run_txn("R3", 1, 4, 1, 1000+20, 0, last_data);
        // R3: start bit on last search pulse accepted; R8 prime count
        add_resp(999, 1, 0, 0, 32'h0, 0);
        run_txn("R8", 0, 1, 0, 999+5+4+100, 0, last_data);
        // R3: one bit too late
        add_resp(1000, 1, 0, 0, 32'h0, 0);
        run_txn("R3", 0, 1, 1, 1000+20, 0, last_data);
        // R9: two busy then ack read
        add_resp(1, 0, 1, 0, 32'h0, 0);
        add_resp(0, 0, 1, 0, 32'h0, 0);
        add_resp(2, 0, 0, 4, 32'hDEADBEEF, 0);
        run_txn("R9", 1, 4, 0, 6+5+(2+5+32+4+100), 2, 32'hDEADBEEF);
        // R9: busy stuck after 100 polls
        for (int i = 0; i < 101; i++) add_resp(0, 3, 1, 0, 32'h0, 0);
        run_txn("R9", 1, 4, 2, 101*5, 100, last_data);
        // R4: busy then command checksum error
        add_resp(0, 1, 1, 0, 32'h0, 0);
        add_resp(0, 1, 3, 0, 32'h0, 0);
        run_txn("R4", 0, 1, 4, 5+25, 1, last_data);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule